// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors run side by side. One reads a table of two-bit counters selected by the recent path of all branches. The other first looks up the branch's own recent outcomes in a per-branch history table. It then reads a table of three-bit counters selected by that history. A third table of two-bit counters, selected by the same global path history, decides which of the two components drives the final answer.

The fetch stage presents a PC on the lookup port. It receives the final direction, the chooser's pick, both component guesses and the global history snapshot in use. When it asserts the lookup valid, the global history shifts in the predicted direction at once. When the branch resolves, the back end returns the PC, the actual direction, both component guesses, the chooser's pick and the history snapshot. The block trains its tables with these values. On a wrong final guess it rebuilds the global history from the snapshot. All tables are untagged, so different branches may share entries.

Top module: `tournament_predictor`

## Requirements
- R1: After reset every counter is weakly not-taken (two-bit counters hold 1, three-bit counters hold 3). Every local history and the global history are zero. A lookup therefore reports not-taken from both components and the local component as the chooser's pick.
- R2: Each global counter steps up on a taken update and down on a not-taken update, and saturates at 0 and 3. Its prediction is the counter MSB, so from a saturated state two opposite updates are needed to flip it.
- R3: Each local counter is three bits wide, saturates at 0 and 7 and predicts with its MSB. From reset one taken update makes it predict taken, and it does not wrap below 0.
- R4: The local history of a branch is selected by PC bits [PC_LSB+LHT_IDX_W-1:PC_LSB]. Each update shifts the actual outcome into bit 0 of that history. The updated history, not the PC, selects the local counter used by the next lookup.
- R5: The chooser counter selected by the snapshot is trained only when the global and local guesses differ. It steps up when the global guess was correct and down when the local guess was correct.
- R6: The final prediction equals the global guess when the chooser counter MSB is set and the local guess otherwise. lkp_use_global_o reports that MSB.
- R7: A lookup with lkp_valid_i high shifts the predicted direction into bit 0 of the global history, where bit i is the outcome of the i-th most recent branch.
- R8: An update whose final prediction (upd_use_global_i ? upd_global_i : upd_local_i) differs from upd_taken_i sets the global history to {upd_ghist_i[GHIST_W-2:0], upd_taken_i}. This repair wins over a lookup in the same cycle.
- R9: An update with a correct final prediction leaves the global history unchanged.
- R10: The tables are untagged. Two PCs that agree in the local index bits share one local history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lkp_valid_i | input | 1 | Lookup is consumed; shift global history |
| lkp_pc_i | input | PC_W | Fetch PC of the branch |
| lkp_taken_o | output | 1 | Final direction prediction |
| lkp_use_global_o | output | 1 | Chooser picks the global component |
| lkp_global_o | output | 1 | Global component guess |
| lkp_local_o | output | 1 | Local component guess |
| lkp_ghist_o | output | GHIST_W | Global history snapshot used by this lookup |
| upd_valid_i | input | 1 | Resolved branch update |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_taken_i | input | 1 | Actual direction |
| upd_global_i | input | 1 | Global guess captured at lookup |
| upd_local_i | input | 1 | Local guess captured at lookup |
| upd_use_global_i | input | 1 | Chooser pick captured at lookup |
| upd_ghist_i | input | GHIST_W | Global history snapshot captured at lookup |

## Verification
The bench builds the block with a 4-bit global history, four local history entries of 3 bits and a 16-bit PC. At these sizes the global snapshot can be chosen so that a repair lands back on the chooser entry just trained, which makes chooser training visible at the lookup port. Distinct PCs collide in the local history table, and short outcome runs steer a branch's history onto a chosen local counter. Counter hysteresis, saturation at both ends and repair priority over a same-cycle lookup are then observable in a few dozen cycles.

// File: rtl/tp_pkg.sv
package tp_pkg;
  // saturating step of a counter no wider than 8 bits
  function automatic logic [7:0] sat_step(input logic [7:0] v, input logic [7:0] vmax,
                                          input logic up);
    if (up) return (v == vmax) ? v : v + 8'd1;
    else    return (v == 8'd0) ? v : v - 8'd1;
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int IDX_W = 10,
  parameter int CTR_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_msb_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] INIT = CTR_W'((1 << (CTR_W - 1)) - 1);
  localparam logic [CTR_W-1:0] CMAX = '1;

  logic [CTR_W-1:0] ctr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= INIT;
    end else if (wr_en_i) begin
      ctr_q[wr_idx_i] <= CTR_W'(tp_pkg::sat_step(8'(ctr_q[wr_idx_i]), 8'(CMAX), wr_up_i));
    end
  end

  assign rd_msb_o = ctr_q[rd_idx_i][CTR_W-1];
endmodule

// File: rtl/tp_lhist_table.sv
module tp_lhist_table #(
  parameter int IDX_W  = 8,
  parameter int HIST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  lkp_idx_i,
  output logic [HIST_W-1:0] lkp_hist_o,
  input  logic [IDX_W-1:0]  upd_idx_i,
  output logic [HIST_W-1:0] upd_hist_o,
  input  logic              wr_en_i,
  input  logic              wr_bit_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (wr_en_i) begin
      hist_q[upd_idx_i] <= {hist_q[upd_idx_i][HIST_W-2:0], wr_bit_i};
    end
  end

  assign lkp_hist_o = hist_q[lkp_idx_i];
  assign upd_hist_o = hist_q[upd_idx_i];
endmodule

// File: rtl/tp_ghist.sv
module tp_ghist #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         spec_en_i,
  input  logic         spec_bit_i,
  input  logic         fix_en_i,
  input  logic [W-1:0] fix_snap_i,
  input  logic         fix_bit_i,
  output logic [W-1:0] hist_o
);
  logic [W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hist_q <= '0;
    else if (fix_en_i)  hist_q <= {fix_snap_i[W-2:0], fix_bit_i};  // repair wins
    else if (spec_en_i) hist_q <= {hist_q[W-2:0], spec_bit_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor #(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int GHIST_W   = 10,
  parameter int LHT_IDX_W = 8,
  parameter int LHIST_W   = 8,
  parameter int GCTR_W    = 2,
  parameter int LCTR_W    = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lkp_valid_i,
  input  logic [PC_W-1:0]    lkp_pc_i,
  output logic               lkp_taken_o,
  output logic               lkp_use_global_o,
  output logic               lkp_global_o,
  output logic               lkp_local_o,
  output logic [GHIST_W-1:0] lkp_ghist_o,
  input  logic               upd_valid_i,
  input  logic [PC_W-1:0]    upd_pc_i,
  input  logic               upd_taken_i,
  input  logic               upd_global_i,
  input  logic               upd_local_i,
  input  logic               upd_use_global_i,
  input  logic [GHIST_W-1:0] upd_ghist_i
);
  logic [GHIST_W-1:0]   ghist;
  logic [LHT_IDX_W-1:0] lkp_lidx, upd_lidx;
  logic [LHIST_W-1:0]   lkp_lhist, upd_lhist;
  logic                 upd_final, upd_miss, comp_differ;

  assign lkp_lidx    = lkp_pc_i[PC_LSB +: LHT_IDX_W];
  assign upd_lidx    = upd_pc_i[PC_LSB +: LHT_IDX_W];
  assign upd_final   = upd_use_global_i ? upd_global_i : upd_local_i;
  assign upd_miss    = upd_valid_i && (upd_final != upd_taken_i);
  assign comp_differ = upd_valid_i && (upd_global_i != upd_local_i);

  tp_ghist #(.W(GHIST_W)) u_ghist (
    .clk_i, .rst_ni,
    .spec_en_i (lkp_valid_i),
    .spec_bit_i(lkp_taken_o),
    .fix_en_i  (upd_miss),
    .fix_snap_i(upd_ghist_i),
    .fix_bit_i (upd_taken_i),
    .hist_o    (ghist)
  );

  tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) u_gtab (
    .clk_i, .rst_ni,
    .rd_idx_i(ghist),
    .rd_msb_o(lkp_global_o),
    .wr_en_i (upd_valid_i),
    .wr_idx_i(upd_ghist_i),
    .wr_up_i (upd_taken_i)
  );

  // chooser: MSB set selects global, trained toward the correct component
  tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) u_choose (
    .clk_i, .rst_ni,
    .rd_idx_i(ghist),
    .rd_msb_o(lkp_use_global_o),
    .wr_en_i (comp_differ),
    .wr_idx_i(upd_ghist_i),
    .wr_up_i (upd_global_i == upd_taken_i)
  );

  tp_lhist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
    .clk_i, .rst_ni,
    .lkp_idx_i (lkp_lidx),
    .lkp_hist_o(lkp_lhist),
    .upd_idx_i (upd_lidx),
    .upd_hist_o(upd_lhist),
    .wr_en_i   (upd_valid_i),
    .wr_bit_i  (upd_taken_i)
  );

  tp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) u_ltab (
    .clk_i, .rst_ni,
    .rd_idx_i(lkp_lhist),
    .rd_msb_o(lkp_local_o),
    .wr_en_i (upd_valid_i),
    .wr_idx_i(upd_lhist),
    .wr_up_i (upd_taken_i)
  );

  assign lkp_taken_o = lkp_use_global_o ? lkp_global_o : lkp_local_o;
  assign lkp_ghist_o = ghist;
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int GHIST_W = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lkp_valid_i,
  input logic               lkp_taken_o,
  input logic [GHIST_W-1:0] lkp_ghist_o,
  input logic               upd_valid_i,
  input logic               upd_taken_i,
  input logic               upd_global_i,
  input logic               upd_local_i,
  input logic               upd_use_global_i,
  input logic [GHIST_W-1:0] upd_ghist_i
);
  logic miss;
  assign miss = upd_valid_i && ((upd_use_global_i ? upd_global_i : upd_local_i) != upd_taken_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) a_r1_ghist_clear: assert (lkp_ghist_o == '0);
  end

  a_r8_repair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss |=> lkp_ghist_o == $past({upd_ghist_i[GHIST_W-2:0], upd_taken_i}));

  a_r7_spec_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && !miss) |=> lkp_ghist_o == $past({lkp_ghist_o[GHIST_W-2:0], lkp_taken_o}));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lkp_valid_i && !miss) |=> $stable(lkp_ghist_o));
endmodule

bind tournament_predictor tp_checker #(.GHIST_W(GHIST_W)) u_tp_checker (
  .clk_i, .rst_ni, .lkp_valid_i, .lkp_taken_o, .lkp_ghist_o,
  .upd_valid_i, .upd_taken_i, .upd_global_i, .upd_local_i,
  .upd_use_global_i, .upd_ghist_i
);

// File: tb/tb_tournament_predictor.sv
module tb_tournament_predictor;
  localparam int CLK_P = 10;
  localparam int PW = 16;
  localparam int GW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lkp_valid = 1'b0;
  logic [PW-1:0] lkp_pc = '0;
  logic          lkp_taken, lkp_use_g, lkp_g, lkp_l;
  logic [GW-1:0] lkp_gh;
  logic          upd_valid = 1'b0;
  logic [PW-1:0] upd_pc = '0;
  logic          upd_taken = 1'b0, upd_g = 1'b0, upd_l = 1'b0, upd_use_g = 1'b0;
  logic [GW-1:0] upd_gh = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  tournament_predictor #(.PC_W(PW), .PC_LSB(2), .GHIST_W(GW), .LHT_IDX_W(2), .LHIST_W(3)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_pc_i(lkp_pc),
    .lkp_taken_o(lkp_taken), .lkp_use_global_o(lkp_use_g),
    .lkp_global_o(lkp_g), .lkp_local_o(lkp_l), .lkp_ghist_o(lkp_gh),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken),
    .upd_global_i(upd_g), .upd_local_i(upd_l), .upd_use_global_i(upd_use_g),
    .upd_ghist_i(upd_gh)
  );

  // {taken, expected global guess at history 0}
  localparam logic [1:0] GVEC [9] = '{2'b11, 2'b11, 2'b11, 2'b01, 2'b00,
                                      2'b00, 2'b00, 2'b10, 2'b11};

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    lkp_valid = 1'b0;
    upd_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic upd(input int pc, input int gh, input bit t, input bit g, input bit l, input bit ug);
    @(negedge clk);
    upd_pc = PW'(pc); upd_gh = GW'(gh); upd_taken = t;
    upd_g = g; upd_l = l; upd_use_g = ug; upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic lookup(input int pc);
    @(negedge clk);
    lkp_pc = PW'(pc); lkp_valid = 1'b1;
    @(negedge clk);
    lkp_valid = 1'b0;
  endtask

  task automatic probe(input int pc);
    lkp_pc = PW'(pc);
    #1;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();

    // R1: reset state
    probe(0);
    chk("R1 taken", lkp_taken, 0);
    chk("R1 use_global", lkp_use_g, 0);
    chk("R1 global", lkp_g, 0);
    chk("R1 local", lkp_l, 0);
    chk("R1 ghist", lkp_gh, 0);

    // R2: global counter hysteresis and saturation, history held at 0
    for (int i = 0; i < 9; i++) begin
      upd(0, 0, GVEC[i][1], GVEC[i][1], GVEC[i][1], 1'b0);
      probe(0);
      chk("R2 global counter", lkp_g, GVEC[i][0]);
    end
    chk("R9 ghist after correct updates", lkp_gh, 0);

    // R3, R4, R10: local history and three-bit counters
    do_reset();
    upd(4, 0, 1, 1, 1, 0);          // local counter[000] 3->4, history[1]=001
    probe(12);
    chk("R3 one taken from reset", lkp_l, 1);
    probe(4);
    chk("R4 history selects counter", lkp_l, 0);
    probe(20);
    chk("R10 aliased pc shares history", lkp_l, 0);
    upd(12, 0, 0, 0, 0, 0);         // counter[000] 4->3
    probe(12);
    chk("R3 weak taken back to not-taken", lkp_l, 0);
    for (int i = 0; i < 4; i++) upd(12, 0, 0, 0, 0, 0);  // 2,1,0,0
    probe(12);
    chk("R3 no wrap below zero", lkp_l, 0);

    // R5, R6, R8, R9: chooser training and final selection
    do_reset();
    upd(0, 15, 1, 1, 0, 0);         // miss, global right: chooser[15] 1->2
    probe(0);
    chk("R8 repair ghist", lkp_gh, 15);
    chk("R5 chooser toward global", lkp_use_g, 1);
    chk("R6 final follows global", lkp_taken, 1);
    chk("R6 local differs", lkp_l, 0);
    upd(0, 15, 0, 0, 0, 1);         // agree, correct
    probe(0);
    chk("R5 no training on agreement", lkp_use_g, 1);
    chk("R9 ghist held", lkp_gh, 15);
    chk("R6 final follows global not-taken", lkp_taken, 0);
    upd(0, 15, 1, 0, 1, 1);         // miss, local right: chooser[15] 2->1
    probe(0);
    chk("R5 chooser toward local", lkp_use_g, 0);
    chk("R8 repair ghist again", lkp_gh, 15);

    // R7: speculative shift of the predicted direction
    probe(0);
    chk("R7 predicted not-taken", lkp_taken, 0);
    lookup(0);
    probe(0);
    chk("R7 shift not-taken", lkp_gh, 14);
    probe(12);
    chk("R7 predicted taken", lkp_taken, 1);
    lookup(12);
    probe(0);
    chk("R7 shift taken", lkp_gh, 13);

    // R8: repair wins over a same-cycle lookup
    @(negedge clk);
    lkp_pc = '0; lkp_valid = 1'b1;
    upd_pc = '0; upd_gh = 4'd3; upd_taken = 1'b0;
    upd_g = 1'b1; upd_l = 1'b1; upd_use_g = 1'b0; upd_valid = 1'b1;
    @(negedge clk);
    lkp_valid = 1'b0; upd_valid = 1'b0;
    probe(0);
    chk("R8 repair priority", lkp_gh, 6);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule